// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the time of day and the calendar as packed BCD fields: seconds, minutes, hours, a weekday code, day of month, month and a two-digit year. A one-cycle `tick_1hz` pulse advances the seconds. The carries then ripple through minutes, hours, day and weekday, month and year in the same clock cycle. Month lengths and leap years are handled by the block. Hours are shown either as 00..23 or in a 12-hour code in which 20 is added to the BCD value for afternoon hours.

A host (typically a serial access port) reads any 4-bit digit combinationally through `rd_addr`/`rd_data`. It writes digits through a valid/ready port. `wr_ready` is low while `busy` is high, and a digit is stored on a clock edge where `wr_valid` and `wr_ready` are both high. A host that sees `wr_ready` low keeps its request, or drops it with no effect. While `cnt_en` is low, seconds ticks are not applied. At most one pending second is kept and applied once counting resumes. A half-minute adjust request rounds the seconds to the nearest minute and pulses `subsec_clr` so that the external prescaler restarts its fraction of a second.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00..59 in BCD. Each wraps to 00 and carries one into the next field in the same clock edge.
- R2: With `mode_24h`=1 the hour runs 0x00..0x23. With `mode_24h`=0 the morning hours are 0x12, 0x01..0x11 and the afternoon hours are 0x32, 0x21..0x31, so bit 1 of the hour-tens digit is the afternoon flag. The step from 0x11 goes to 0x32, and the step from 0x31 goes to 0x12.
- R3: The step from 0x23 (24-hour mode) or 0x31 (12-hour mode) advances the day and the weekday. The weekday counts 0..6 and then returns to 0, and counting never makes the value 7.
- R4: The last day is 0x31 for months 1, 3, 5, 7, 8, 10 and 12, and 0x30 for months 4, 6, 9 and 11. For month 2 it is 0x29 when the year value is a multiple of 4 (00 included) and 0x28 otherwise. After the last day comes day 0x01 of the next month.
- R5: After month 0x12 comes month 0x01, and the year advances. The year runs 0x00..0x99 and wraps to 0x00.
- R6: A tick that arrives while `cnt_en`=0 is held, and `busy` stays high while it is held. When `cnt_en` returns to 1, exactly one second is added, however many ticks were held.
- R7: An adjust request sets the seconds to 00. If the seconds were 30 or more, the minute also advances, with the full carry chain. The adjust waits until `cnt_en`=1. It takes priority over a held or coinciding tick, and that tick is dropped. `subsec_clr` is high for the one cycle that follows the edge where the adjust takes effect.
- R8: After any edge that applies a seconds step or an adjust, `busy` stays high for `BUSY_HOLD` cycles.
- R9: `wr_ready` equals not `busy`. An accepted write can be read back in the next cycle, and a request made while `wr_ready`=0 changes nothing. A tick that coincides with an accepted write is held and applied on the next edge.
- R10: Digit addresses are: 0/1 seconds units/tens, 2/3 minutes units/tens, 4/5 hour units/tens, 6 weekday, 7/8 day units/tens, 9/10 month units/tens, 11/12 year units/tens. The tens of seconds and of minutes keep 3 bits, and the hour tens and day tens keep 2. The weekday keeps 3 bits and the month tens 1. Bits that are not kept read 0, and addresses 13..15 read 0.
- R11: After reset the time is 00:00:00, the weekday is 0, the date is day 01, month 01, year 00, and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| cnt_en | input | 1 | Counting enable; low holds seconds ticks |
| adj_req | input | 1 | One-cycle request to round the seconds to the minute |
| mode_24h | input | 1 | 1: 24-hour code, 0: 12-hour code with afternoon flag |
| wr_valid | input | 1 | Digit write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | 4 | Digit address for the write |
| wr_data | input | 4 | Digit value to write |
| rd_addr | input | 4 | Digit address for the read |
| rd_data | output | 4 | Digit value, combinational from `rd_addr` |
| busy | output | 1 | Step or adjust pending, or recently applied |
| subsec_clr | output | 1 | One-cycle pulse: restart the sub-second count |

## Verification
The carry chain is tried from states set just below every boundary: the full 23:59:59, Dec 31 of year 99 rollover, each month-end kind, February in leap, non-leap and year-00 years, and the 12-hour noon and midnight codes. Each of these shows whether a single carry stage is wrong or missing. Held ticks are sent in bursts while counting is off, and the bench then checks that exactly one second appears. Adjust requests go in with seconds on both sides of 30, with a held tick present, to separate rounding from the tick path. A seeded random run starts from states close to rollovers in both hour modes, applies a mix of ticks and adjusts, and compares every digit with an integer model.

// File: rtl/rtcc_pkg.sv
`timescale 1ns/1ps
package rtcc_pkg;

  typedef enum logic [3:0] {
    A_SEC_U = 4'd0,
    A_SEC_T = 4'd1,
    A_MIN_U = 4'd2,
    A_MIN_T = 4'd3,
    A_HR_U  = 4'd4,
    A_HR_T  = 4'd5,
    A_WDAY  = 4'd6,
    A_DAY_U = 4'd7,
    A_DAY_T = 4'd8,
    A_MON_U = 4'd9,
    A_MON_T = 4'd10,
    A_YR_U  = 4'd11,
    A_YR_T  = 4'd12
  } dig_addr_e;

  localparam logic [7:0] SEC_MASK = 8'h7F;
  localparam logic [7:0] HR_MASK  = 8'h3F;
  localparam logic [7:0] DAY_MASK = 8'h3F;
  localparam logic [7:0] MON_MASK = 8'h1F;

  // Advance a packed two-digit BCD value by one, units rolling into tens.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_step = {v[7:4] + 4'd1, 4'd0};
    else                bcd_step = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Next hour code; bit 8 of the result is the carry into the day.
  function automatic logic [8:0] hour_step(input logic [7:0] h, input logic m24);
    logic [7:0] low;
    logic       pm;
    low = h & 8'h1F;
    pm  = h[5];
    if (m24) begin
      if (h == 8'h23) hour_step = {1'b1, 8'h00};
      else            hour_step = {1'b0, bcd_step(h)};
    end else if (low == 8'h12) begin
      hour_step = {1'b0, (pm ? 8'h21 : 8'h01)};
    end else if (low == 8'h11) begin
      hour_step = pm ? {1'b1, 8'h12} : {1'b0, 8'h32};
    end else begin
      hour_step = {1'b0, bcd_step(low) | (pm ? 8'h20 : 8'h00)};
    end
  endfunction

  // Year value is a multiple of four.
  function automatic logic leap_year(input logic [7:0] y);
    leap_year = ((({4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]}) & 8'h03) == 8'h00);
  endfunction

  // Last day of the month, BCD.
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] y);
    case (mon)
      8'h02:                      last_day = leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcc_ctrl.sv
`timescale 1ns/1ps
module rtcc_ctrl #(
  parameter int BUSY_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cnt_en,
  input  logic adj_req,
  input  logic wr_valid,
  output logic wr_ready,
  output logic wr_go,
  output logic step_go,
  output logic adj_go,
  output logic busy,
  output logic subsec_clr
);
  localparam int HOLD_W = $clog2(BUSY_HOLD + 1);

  logic              tick_pend;
  logic              adj_pend;
  logic [HOLD_W-1:0] hold_cnt;

  assign busy     = tick_pend | adj_pend | (hold_cnt != '0);
  assign wr_ready = !busy;
  assign wr_go    = wr_valid && wr_ready;
  assign adj_go   = cnt_en && !wr_go && (adj_req || adj_pend);
  assign step_go  = cnt_en && !wr_go && !adj_go && (tick || tick_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_pend  <= 1'b0;
      adj_pend   <= 1'b0;
      hold_cnt   <= '0;
      subsec_clr <= 1'b0;
    end else begin
      tick_pend  <= (tick || tick_pend) && !step_go && !adj_go;
      adj_pend   <= (adj_req || adj_pend) && !adj_go;
      subsec_clr <= adj_go;
      if (step_go || adj_go)  hold_cnt <= HOLD_W'(BUSY_HOLD);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - HOLD_W'(1);
    end
  end

  // R6
  held_tick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_en) |=> busy);

  // R7
  held_adj_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_req && !cnt_en) |=> busy);

  // R8
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go || adj_go) |=> busy);

  // R7
  adj_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_go |=> (subsec_clr && busy));

endmodule

// File: rtl/rtcc_clock.sv
`timescale 1ns/1ps
module rtcc_clock
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_24h,
  input  logic       step,
  input  logic       adj,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] mn,
  output logic [7:0] hr,
  output logic       day_carry
);
  logic       min_inc;
  logic       hr_inc;
  logic [8:0] hr_nx;

  always_comb begin
    min_inc   = (step && sec == 8'h59) || (adj && sec >= 8'h30);
    hr_inc    = min_inc && mn == 8'h59;
    hr_nx     = hour_step(hr, mode_24h);
    day_carry = hr_inc && hr_nx[8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00;
      mn  <= 8'h00;
      hr  <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        A_SEC_U: sec[3:0] <= wr_data;
        A_SEC_T: sec[7:4] <= {1'b0, wr_data[2:0]};
        A_MIN_U: mn[3:0]  <= wr_data;
        A_MIN_T: mn[7:4]  <= {1'b0, wr_data[2:0]};
        A_HR_U:  hr[3:0]  <= wr_data;
        A_HR_T:  hr[7:4]  <= {2'b00, wr_data[1:0]};
        default: ;
      endcase
    end else begin
      if (adj)       sec <= 8'h00;
      else if (step) sec <= (sec == 8'h59) ? 8'h00 : (bcd_step(sec) & SEC_MASK);
      if (min_inc)   mn  <= (mn == 8'h59) ? 8'h00 : (bcd_step(mn) & SEC_MASK);
      if (hr_inc)    hr  <= hr_nx[7:0] & HR_MASK;
    end
  end

  // R1
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !adj && !wr_en && sec == 8'h59) |=> (sec == 8'h00));

  // R2
  noon_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_inc && !wr_en && !mode_24h && hr == 8'h11) |=> (hr == 8'h32));

  // R7
  adj_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj && !wr_en) |=> (sec == 8'h00));

  // R9
  wr_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SEC_U) |=> (sec[3:0] == $past(wr_data)));

endmodule

// File: rtl/rtcc_date.sv
`timescale 1ns/1ps
module rtcc_date
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_inc,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic [2:0] wday,
  output logic [7:0] day,
  output logic [7:0] mon,
  output logic [7:0] yr
);
  logic [7:0] last;
  logic       mon_inc;
  logic       yr_inc;

  always_comb begin
    last    = last_day(mon, yr);
    mon_inc = day_inc && day == last;
    yr_inc  = mon_inc && mon == 8'h12;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday <= 3'd0;
      day  <= 8'h01;
      mon  <= 8'h01;
      yr   <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        A_WDAY:  wday     <= wr_data[2:0];
        A_DAY_U: day[3:0] <= wr_data;
        A_DAY_T: day[7:4] <= {2'b00, wr_data[1:0]};
        A_MON_U: mon[3:0] <= wr_data;
        A_MON_T: mon[7:4] <= {3'b000, wr_data[0]};
        A_YR_U:  yr[3:0]  <= wr_data;
        A_YR_T:  yr[7:4]  <= wr_data;
        default: ;
      endcase
    end else if (day_inc) begin
      wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
      day  <= mon_inc ? 8'h01 : (bcd_step(day) & DAY_MASK);
      if (mon_inc) mon <= yr_inc ? 8'h01 : (bcd_step(mon) & MON_MASK);
      if (yr_inc)  yr  <= (yr == 8'h99) ? 8'h00 : bcd_step(yr);
    end
  end

  // R3
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !wr_en && wday == 3'd6) |=> (wday == 3'd0));

  // R3
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !wr_en && wday != 3'd7) |=> (wday != 3'd7));

  // R4
  feb_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !wr_en && mon == 8'h02 && day == 8'h28 && yr == 8'h04) |=> (day == 8'h29));

  // R5
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !wr_en && mon == 8'h12 && day == 8'h31 && yr == 8'h99)
      |=> (yr == 8'h00 && mon == 8'h01 && day == 8'h01));

endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
  import rtcc_pkg::*;
#(
  parameter int BUSY_HOLD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       cnt_en,
  input  logic       adj_req,
  input  logic       mode_24h,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [3:0] rd_data,
  output logic       busy,
  output logic       subsec_clr
);
  logic       wr_go;
  logic       step_go;
  logic       adj_go;
  logic       day_carry;
  logic [7:0] sec, mn, hr, day, mon, yr;
  logic [2:0] wday;

  rtcc_ctrl #(.BUSY_HOLD(BUSY_HOLD)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_1hz),
    .cnt_en     (cnt_en),
    .adj_req    (adj_req),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_go      (wr_go),
    .step_go    (step_go),
    .adj_go     (adj_go),
    .busy       (busy),
    .subsec_clr (subsec_clr)
  );

  rtcc_clock u_clock (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_24h  (mode_24h),
    .step      (step_go),
    .adj       (adj_go),
    .wr_en     (wr_go),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sec       (sec),
    .mn        (mn),
    .hr        (hr),
    .day_carry (day_carry)
  );

  rtcc_date u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .day_inc (day_carry),
    .wr_en   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wday    (wday),
    .day     (day),
    .mon     (mon),
    .yr      (yr)
  );

  always_comb begin
    case (rd_addr)
      A_SEC_U: rd_data = sec[3:0];
      A_SEC_T: rd_data = sec[7:4];
      A_MIN_U: rd_data = mn[3:0];
      A_MIN_T: rd_data = mn[7:4];
      A_HR_U:  rd_data = hr[3:0];
      A_HR_T:  rd_data = hr[7:4];
      A_WDAY:  rd_data = {1'b0, wday};
      A_DAY_U: rd_data = day[3:0];
      A_DAY_T: rd_data = day[7:4];
      A_MON_U: rd_data = mon[3:0];
      A_MON_T: rd_data = mon[7:4];
      A_YR_U:  rd_data = yr[3:0];
      A_YR_T:  rd_data = yr[7:4];
      default: rd_data = 4'h0;
    endcase
  end

endmodule

// File: tb/rtc_bcd_calendar_test.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_test;
  localparam int HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cnt_en = 1'b1, adj_req = 1'b0;
  logic mode_24h = 1'b1, wr_valid = 1'b0;
  logic [3:0] wr_addr = 4'h0, wr_data = 4'h0, rd_addr = 4'h0;
  logic wr_ready, busy, subsec_clr;
  logic [3:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar #(.BUSY_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .cnt_en(cnt_en), .adj_req(adj_req),
    .mode_24h(mode_24h), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .subsec_clr(subsec_clr)
  );

  function automatic int bcd(input int v);
    return (v / 10) * 16 + v % 10;
  endfunction

  function automatic int mdays(input int mo, input int y);
    case (mo)
      2:          return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:    return 31;
    endcase
  endfunction

  function automatic int hr_code(input int h);
    int h12;
    if (mode_24h) return bcd(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return bcd(h12) + ((h >= 12) ? 32 : 0);
  endfunction

  function automatic int exp_dig(input int a);
    case (a)
      0:  return bcd(m_sec) % 16;
      1:  return bcd(m_sec) / 16;
      2:  return bcd(m_min) % 16;
      3:  return bcd(m_min) / 16;
      4:  return hr_code(m_hr) % 16;
      5:  return hr_code(m_hr) / 16;
      6:  return m_wd;
      7:  return bcd(m_day) % 16;
      8:  return bcd(m_day) / 16;
      9:  return bcd(m_mon) % 16;
      10: return bcd(m_mon) / 16;
      11: return bcd(m_yr) % 16;
      12: return bcd(m_yr) / 16;
      default: return 0;
    endcase
  endfunction

  function automatic void m_min_inc();
    m_min++;
    if (m_min == 60) begin
      m_min = 0; m_hr++;
      if (m_hr == 24) begin
        m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
        if (m_day > mdays(m_mon, m_yr)) begin
          m_day = 1; m_mon++;
          if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
        end
      end
    end
  endfunction

  function automatic void m_sec_inc();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min_inc(); end
  endfunction

  function automatic void m_adjust();
    if (m_sec >= 30) m_min_inc();
    m_sec = 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 4'(a);
    #0.5;
    v = int'(rd_data);
  endtask

  task automatic cmp_all(input string ctx);
    int v;
    string tg;
    for (int a = 0; a < 13; a++) begin
      rd(a, v);
      tg = (a < 4) ? "R1" : (a < 6) ? "R2" : (a == 6) ? "R3" : (a < 9) ? "R4" : "R5";
      chk(tg, $sformatf("%s digit %0d", ctx, a), v, exp_dig(a));
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wr_dig(input int a, input int d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'(a); wr_data = 4'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_all(input int s, input int m, input int h, input int wd,
                         input int d, input int mo, input int y);
    m_sec = s; m_min = m; m_hr = h; m_wd = wd; m_day = d; m_mon = mo; m_yr = y;
    for (int a = 0; a < 13; a++) wr_dig(a, exp_dig(a));
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    m_sec_inc();
    wait_idle();
  endtask

  task automatic do_adj();
    @(negedge clk); adj_req = 1'b1;
    @(negedge clk); adj_req = 1'b0;
    m_adjust();
    wait_idle();
  endtask

  task automatic roll_day(input int d, input int mo, input int y);
    set_all(59, 59, 23, 3, d, mo, y);
    do_tick();
    cmp_all($sformatf("month end %0d/%0d/%0d", d, mo, y));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v, r, s, m, h, mo, y, d, lst, k;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_day = 1; m_mon = 1; m_yr = 0;
    chk("R11", "busy after reset", int'(busy), 0);
    chk("R9", "ready after reset", int'(wr_ready), 1);
    for (int a = 0; a < 13; a++) begin
      rd(a, v);
      chk("R11", $sformatf("reset digit %0d", a), v, exp_dig(a));
    end

    // R1 R3 R5 full rollover in 24-hour mode
    set_all(59, 59, 23, 6, 31, 12, 99);
    do_tick();
    cmp_all("year rollover");
    rd(6, v); chk("R3", "weekday wraps 6->0", v, 0);

    // R1 minute carry only
    set_all(59, 14, 9, 2, 5, 6, 30);
    do_tick();
    cmp_all("minute carry");

    // R4 month lengths and leap years
    roll_day(28, 2, 4);
    roll_day(29, 2, 4);
    roll_day(28, 2, 5);
    roll_day(28, 2, 0);
    roll_day(30, 4, 10);
    roll_day(30, 8, 10);
    roll_day(31, 1, 21);
    roll_day(30, 11, 77);

    // R2 12-hour code boundaries
    mode_24h = 1'b0;
    set_all(59, 59, 11, 1, 10, 3, 20);
    do_tick();
    cmp_all("AM11 to PM12");
    rd(5, v); chk("R2", "afternoon flag in hour tens", v, 3);
    set_all(59, 59, 23, 1, 10, 3, 20);
    do_tick();
    cmp_all("PM11 to AM12");
    set_all(59, 59, 0, 1, 10, 3, 20);
    do_tick();
    cmp_all("AM12 to AM1");
    set_all(59, 59, 12, 1, 10, 3, 20);
    do_tick();
    cmp_all("PM12 to PM1");
    set_all(59, 59, 21, 1, 10, 3, 20);
    do_tick();
    cmp_all("PM9 to PM10");
    mode_24h = 1'b1;

    // R6 held ticks give one second
    set_all(10, 20, 5, 4, 12, 7, 15);
    @(negedge clk); cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    chk("R6", "busy while tick held", int'(busy), 1);
    chk("R9", "ready low while tick held", int'(wr_ready), 0);
    rd(0, v); chk("R6", "seconds frozen while disabled", v, 0);
    @(negedge clk); wr_valid = 1'b1; wr_addr = 4'd0; wr_data = 4'd9;
    @(negedge clk); wr_valid = 1'b0;
    cnt_en = 1'b1;
    wait_idle();
    m_sec_inc();
    cmp_all("held tick single step");
    rd(0, v); chk("R6", "exactly one second after re-enable", v, 1);

    // R7 adjust with seconds at or above 30
    set_all(45, 59, 23, 6, 31, 12, 99);
    @(negedge clk); adj_req = 1'b1;
    @(negedge clk); adj_req = 1'b0;
    chk("R7", "subsec_clr pulse", int'(subsec_clr), 1);
    @(negedge clk);
    chk("R7", "subsec_clr ends", int'(subsec_clr), 0);
    m_adjust();
    wait_idle();
    cmp_all("adjust round up cascade");

    // R7 adjust below 30
    set_all(12, 40, 8, 0, 3, 3, 33);
    do_adj();
    cmp_all("adjust round down");

    // R7 adjust waits for enable and drops a held tick
    set_all(29, 40, 8, 0, 3, 3, 33);
    @(negedge clk); cnt_en = 1'b0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; adj_req = 1'b1;
    @(negedge clk); adj_req = 1'b0;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R7", "adjust deferred while disabled", v, 9);
    chk("R7", "busy while adjust held", int'(busy), 1);
    cnt_en = 1'b1;
    wait_idle();
    m_adjust();
    cmp_all("adjust over held tick");

    // R8 busy hold length
    wait_idle();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    m_sec_inc();
    for (int i = 0; i < HOLD; i++) begin
      chk("R8", $sformatf("busy hold cycle %0d", i), int'(busy), 1);
      @(negedge clk);
    end
    chk("R8", "busy released", int'(busy), 0);
    cmp_all("after busy hold");

    // R9 tick coinciding with accepted write
    set_all(34, 1, 2, 3, 4, 5, 6);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'd0; wr_data = 4'd5; tick = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; tick = 1'b0;
    rd(0, v); chk("R9", "write visible next cycle", v, 5);
    chk("R9", "held tick makes busy", int'(busy), 1);
    @(negedge clk);
    rd(0, v); chk("R9", "deferred tick applied", v, 6);
    m_sec = 36;
    wait_idle();
    cmp_all("write with tick");

    // R10 kept bits and unused addresses
    for (int a = 0; a < 16; a++) wr_dig(a, 15);
    wait_idle();
    rd(1, v);  chk("R10", "seconds tens width", v, 7);
    rd(3, v);  chk("R10", "minutes tens width", v, 7);
    rd(5, v);  chk("R10", "hour tens width", v, 3);
    rd(6, v);  chk("R10", "weekday width", v, 7);
    rd(8, v);  chk("R10", "day tens width", v, 3);
    rd(10, v); chk("R10", "month tens width", v, 1);
    rd(12, v); chk("R10", "year tens width", v, 15);
    for (int a = 13; a < 16; a++) begin
      rd(a, v); chk("R10", $sformatf("unused address %0d", a), v, 0);
    end

    // random states near rollovers
    for (int it = 0; it < 40; it++) begin
      mode_24h = 1'($urandom % 2);
      s  = 55 + int'($urandom % 5);
      m  = ($urandom % 3 == 0) ? int'($urandom % 60) : 59;
      h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      lst = mdays(mo, y);
      r  = int'($urandom % 3);
      d  = (r == 0) ? lst : (r == 1) ? lst - 1 : 1 + int'($urandom % lst);
      set_all(s, m, h, int'($urandom % 7), d, mo, y);
      k = 1 + int'($urandom % 6);
      for (int j = 0; j < k; j++) begin
        if ($urandom % 4 == 0) do_adj();
        else do_tick();
      end
      cmp_all($sformatf("random %0d", it));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule